// File: doc/BRIEF.md
# Dual-Bank Masked GPIO Controller

This block runs one 32-bit port of general-purpose pins. Two register banks are attached to it, and each bank keeps its own output latch and direction register. The legacy bank sits on a simple word-wide peripheral bus and has pin, set, clear and direction registers. The enhanced bank sits on a fast local bus. It accepts byte-lane writes, and it has a mask register that keeps chosen port bits out of its output writes and pin reads.

A single select input decides which bank drives the pad output levels and output enables. The other bank keeps working on its own state, but that state does not reach the pads. Pad inputs pass through a two-flop synchronizer, and both banks' pin registers read the synchronized levels. Read data on both buses is combinational from the address while a read request is active. A write takes effect at the clock edge where it is presented.

Top module: `gpio_dual_bank`

## Requirements
- R1: After reset, every output latch, direction register and mask register is zero. While reset is active and after it is released, `pad_oe_o` and `pad_out_o` are zero.
- R2: On the legacy bank, a write to offset 0x4 (set) raises every latch bit where the write data is one. Bits where the data is zero keep their value. A read of offset 0x4 returns the latch.
- R3: On the legacy bank, a write to offset 0xC (clear) lowers every latch bit where the write data is one, so the set register reads those bits back as zero. Bits where the data is zero keep their value. A read of 0xC returns zero.
- R4: A read of the pin register (legacy 0x0, enhanced 0x08) returns the pad input levels as they were two clock edges earlier, whatever each pin's direction.
- R5: `bank_sel_i` = 0 drives the pads from the legacy bank and `bank_sel_i` = 1 drives them from the enhanced bank. For each pin, the output enable is the selected bank's direction bit and the level is that bank's latch bit.
- R6: A write to one bank never changes the registers of the other bank.
- R7: On the enhanced bank, `fs_be_i[k]` enables bits 8k+7..8k of a write. Disabled bytes keep their value, and a write with no byte enabled changes nothing.
- R8: On the enhanced bank, with mask offset 0x04, a latch bit whose mask bit is one is left unchanged by set (0x0C), clear (0x10) and pin (0x08) writes, and reads as zero in the pin register.
- R9: Reads of unmapped offsets, and of the enhanced clear register (0x10), return zero. Writes to unmapped offsets change no register.
- R10: On the legacy bank, a write to offset 0x0 (pin) loads the output latch with the write data. Offset 0x8 is the direction register, where one means output. On the enhanced bank, offset 0x00 is direction and a pin write replaces the unmasked, enabled latch bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bank_sel_i | input | 1 | 0: legacy bank drives pads, 1: enhanced bank |
| lg_req_i | input | 1 | Legacy bus access request |
| lg_we_i | input | 1 | Legacy bus write when 1, read when 0 |
| lg_addr_i | input | 4 | Legacy byte offset |
| lg_wdata_i | input | 32 | Legacy write data |
| lg_rdata_o | output | 32 | Legacy read data |
| fs_req_i | input | 1 | Enhanced bus access request |
| fs_we_i | input | 1 | Enhanced bus write when 1, read when 0 |
| fs_addr_i | input | 5 | Enhanced byte offset |
| fs_be_i | input | 4 | Enhanced write byte enables |
| fs_wdata_i | input | 32 | Enhanced write data |
| fs_rdata_o | output | 32 | Enhanced read data |
| pad_in_i | input | 32 | Pad input levels |
| pad_out_o | output | 32 | Pad output levels |
| pad_oe_o | output | 32 | Pad output enables |

## Verification
Several properties are checked on every cycle. A legacy set or clear write reaches the pads on the next cycle while the legacy bank is selected. A write with no byte enabled leaves the pads unchanged. Pin reads lag the pads by exactly two edges, and clear and unmapped offsets read zero. The bench scenarios are needed for the rest: that the two banks stay independent across a bank switch, that masked bits are shielded from writes and reads, how byte lanes combine with the mask, and that unmapped writes leave every register untouched.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int unsigned LG_AW = 4;
  localparam int unsigned FS_AW = 5;

  localparam logic [LG_AW-1:0] LG_PIN = 4'h0;
  localparam logic [LG_AW-1:0] LG_SET = 4'h4;
  localparam logic [LG_AW-1:0] LG_DIR = 4'h8;
  localparam logic [LG_AW-1:0] LG_CLR = 4'hC;

  localparam logic [FS_AW-1:0] FS_DIR  = 5'h00;
  localparam logic [FS_AW-1:0] FS_MASK = 5'h04;
  localparam logic [FS_AW-1:0] FS_PIN  = 5'h08;
  localparam logic [FS_AW-1:0] FS_SET  = 5'h0C;
  localparam logic [FS_AW-1:0] FS_CLR  = 5'h10;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_legacy_bank.sv
module gpio_legacy_bank
  import gpio_dual_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [LG_AW-1:0] addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     pin_sync_i,
  output logic [W-1:0]     rdata_o,
  output logic [W-1:0]     out_o,
  output logic [W-1:0]     dir_o
);
  logic [W-1:0] out_q, dir_q;
  logic         wr;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (wr) begin
      unique case (addr_i)
        LG_PIN:  out_q <= wdata_i;
        LG_SET:  out_q <= out_q | wdata_i;
        LG_CLR:  out_q <= out_q & ~wdata_i;
        LG_DIR:  dir_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        LG_PIN:  rdata_o = pin_sync_i;
        LG_SET:  rdata_o = out_q;
        LG_DIR:  rdata_o = dir_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/gpio_fast_bank.sv
module gpio_fast_bank
  import gpio_dual_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned NB = W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [FS_AW-1:0] addr_i,
  input  logic [NB-1:0]    be_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     pin_sync_i,
  output logic [W-1:0]     rdata_o,
  output logic [W-1:0]     out_o,
  output logic [W-1:0]     dir_o
);
  logic [W-1:0] out_q, dir_q, mask_q;
  logic [W-1:0] lane, wbits;
  logic         wr;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g*8 +: 8] = {8{be_i[g]}};
  end

  assign wr    = req_i & we_i;
  assign wbits = lane & ~mask_q;  // bits an output write may touch

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      unique case (addr_i)
        FS_DIR:  dir_q  <= (dir_q & ~lane) | (wdata_i & lane);
        FS_MASK: mask_q <= (mask_q & ~lane) | (wdata_i & lane);
        FS_PIN:  out_q  <= (out_q & ~wbits) | (wdata_i & wbits);
        FS_SET:  out_q  <= out_q | (wdata_i & wbits);
        FS_CLR:  out_q  <= out_q & ~(wdata_i & wbits);
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        FS_DIR:  rdata_o = dir_q;
        FS_MASK: rdata_o = mask_q;
        FS_PIN:  rdata_o = pin_sync_i & ~mask_q;
        FS_SET:  rdata_o = out_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank
  import gpio_dual_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned NB = W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bank_sel_i,
  input  logic             lg_req_i,
  input  logic             lg_we_i,
  input  logic [LG_AW-1:0] lg_addr_i,
  input  logic [W-1:0]     lg_wdata_i,
  output logic [W-1:0]     lg_rdata_o,
  input  logic             fs_req_i,
  input  logic             fs_we_i,
  input  logic [FS_AW-1:0] fs_addr_i,
  input  logic [NB-1:0]    fs_be_i,
  input  logic [W-1:0]     fs_wdata_i,
  output logic [W-1:0]     fs_rdata_o,
  input  logic [W-1:0]     pad_in_i,
  output logic [W-1:0]     pad_out_o,
  output logic [W-1:0]     pad_oe_o
);
  logic [W-1:0] pin_sync;
  logic [W-1:0] lg_out, lg_dir, fs_out, fs_dir;

  gpio_sync #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  gpio_legacy_bank #(.W(W)) u_legacy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (lg_req_i),
    .we_i       (lg_we_i),
    .addr_i     (lg_addr_i),
    .wdata_i    (lg_wdata_i),
    .pin_sync_i (pin_sync),
    .rdata_o    (lg_rdata_o),
    .out_o      (lg_out),
    .dir_o      (lg_dir)
  );

  gpio_fast_bank #(.W(W)) u_fast (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (fs_req_i),
    .we_i       (fs_we_i),
    .addr_i     (fs_addr_i),
    .be_i       (fs_be_i),
    .wdata_i    (fs_wdata_i),
    .pin_sync_i (pin_sync),
    .rdata_o    (fs_rdata_o),
    .out_o      (fs_out),
    .dir_o      (fs_dir)
  );

  assign pad_out_o = bank_sel_i ? fs_out : lg_out;
  assign pad_oe_o  = bank_sel_i ? fs_dir : lg_dir;
endmodule

// File: rtl/gpio_dual_bank_chk.sv
module gpio_dual_bank_chk
  import gpio_dual_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned NB = W / 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bank_sel_i,
  input logic             lg_req_i,
  input logic             lg_we_i,
  input logic [LG_AW-1:0] lg_addr_i,
  input logic [W-1:0]     lg_wdata_i,
  input logic [W-1:0]     lg_rdata_o,
  input logic             fs_req_i,
  input logic             fs_we_i,
  input logic [FS_AW-1:0] fs_addr_i,
  input logic [NB-1:0]    fs_be_i,
  input logic [W-1:0]     fs_rdata_o,
  input logic [W-1:0]     pad_in_i,
  input logic [W-1:0]     pad_out_o,
  input logic [W-1:0]     pad_oe_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd0) |-> (pad_oe_o == '0 && pad_out_o == '0)); // R1

  AST_LG_SET_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lg_req_i && lg_we_i && lg_addr_i == LG_SET && !bank_sel_i) |=>
    (bank_sel_i || ((pad_out_o & $past(lg_wdata_i)) == $past(lg_wdata_i)))); // R2

  AST_LG_CLR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lg_req_i && lg_we_i && lg_addr_i == LG_CLR && !bank_sel_i) |=>
    (bank_sel_i || ((pad_out_o & $past(lg_wdata_i)) == '0))); // R3

  AST_LG_CLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lg_req_i && !lg_we_i && lg_addr_i == LG_CLR) |-> (lg_rdata_o == '0)); // R3

  AST_PIN_SYNC_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && lg_req_i && !lg_we_i && lg_addr_i == LG_PIN) |->
    (lg_rdata_o == $past(pad_in_i, 2))); // R4

  AST_NO_LANE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_req_i && fs_we_i && fs_be_i == '0 && bank_sel_i) |=>
    (!bank_sel_i || ($stable(pad_out_o) && $stable(pad_oe_o)))); // R7

  AST_FS_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_req_i && !fs_we_i && fs_addr_i >= FS_CLR) |-> (fs_rdata_o == '0)); // R9
endmodule

bind gpio_dual_bank gpio_dual_bank_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bank_sel_i (bank_sel_i),
  .lg_req_i   (lg_req_i),
  .lg_we_i    (lg_we_i),
  .lg_addr_i  (lg_addr_i),
  .lg_wdata_i (lg_wdata_i),
  .lg_rdata_o (lg_rdata_o),
  .fs_req_i   (fs_req_i),
  .fs_we_i    (fs_we_i),
  .fs_addr_i  (fs_addr_i),
  .fs_be_i    (fs_be_i),
  .fs_rdata_o (fs_rdata_o),
  .pad_in_i   (pad_in_i),
  .pad_out_o  (pad_out_o),
  .pad_oe_o   (pad_oe_o)
);

// File: tb/gpio_dual_bank_bench.sv
`timescale 1ns/1ps
module gpio_dual_bank_bench;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bank_sel = 1'b0;
  logic        lg_req = 1'b0, lg_we = 1'b0;
  logic [3:0]  lg_addr = '0;
  logic [31:0] lg_wdata = '0, lg_rdata;
  logic        fs_req = 1'b0, fs_we = 1'b0;
  logic [4:0]  fs_addr = '0;
  logic [3:0]  fs_be = '0;
  logic [31:0] fs_wdata = '0, fs_rdata;
  logic [31:0] ext_in = '0;
  logic [31:0] pad_in, pad_out, pad_oe;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  // Pads: driven pins reflect the output level, the rest follow the outside world
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

  gpio_dual_bank u_gpio_dual_bank (
    .clk_i(clk), .rst_ni(rst_ni), .bank_sel_i(bank_sel),
    .lg_req_i(lg_req), .lg_we_i(lg_we), .lg_addr_i(lg_addr),
    .lg_wdata_i(lg_wdata), .lg_rdata_o(lg_rdata),
    .fs_req_i(fs_req), .fs_we_i(fs_we), .fs_addr_i(fs_addr),
    .fs_be_i(fs_be), .fs_wdata_i(fs_wdata), .fs_rdata_o(fs_rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  // {offset[3:0], write data, expected set-register readback}
  localparam logic [67:0] VEC [8] = '{
    {4'h4, 32'h0000_00FF, 32'h0000_00FF},
    {4'h4, 32'hF000_0000, 32'hF000_00FF},
    {4'h4, 32'h0000_0000, 32'hF000_00FF},
    {4'hC, 32'h0000_000F, 32'hF000_00F0},
    {4'hC, 32'h0000_0000, 32'hF000_00F0},
    {4'h0, 32'h1234_5678, 32'h1234_5678},
    {4'hC, 32'hFFFF_0000, 32'h0000_5678},
    {4'h4, 32'h8000_0001, 32'h8000_5679}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    lg_req = 1'b1; lg_we = 1'b1; lg_addr = a; lg_wdata = d;
    @(negedge clk);
    lg_req = 1'b0; lg_we = 1'b0;
  endtask

  task automatic lg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    lg_req = 1'b1; lg_we = 1'b0; lg_addr = a;
    #1 d = lg_rdata;
  endtask

  task automatic fs_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    fs_req = 1'b1; fs_we = 1'b1; fs_addr = a; fs_be = be; fs_wdata = d;
    @(negedge clk);
    fs_req = 1'b0; fs_we = 1'b0;
  endtask

  task automatic fs_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    fs_req = 1'b1; fs_we = 1'b0; fs_addr = a;
    #1 d = fs_rdata;
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    #1;
    check("R1 oe in reset", pad_oe, 32'h0);
    check("R1 out in reset", pad_out, 32'h0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    lg_rd(4'h4, r); check("R1 legacy latch", r, 32'h0);
    lg_rd(4'h8, r); check("R1 legacy dir", r, 32'h0);
    fs_rd(5'h00, r); check("R1 fast dir", r, 32'h0);
    fs_rd(5'h04, r); check("R1 fast mask", r, 32'h0);

    // Legacy set/clear/pin sequence
    for (int i = 0; i < 8; i++) begin
      lg_wr(VEC[i][67:64], VEC[i][63:32]);
      lg_rd(4'h4, r);
      check(VEC[i][67:64] == 4'h4 ? "R2 set" : VEC[i][67:64] == 4'hC ? "R3 clr" : "R10 pin wr",
            r, VEC[i][31:0]);
    end
    lg_rd(4'hC, r); check("R3 clr reads zero", r, 32'h0);

    // Synchronizer latency with all pins as inputs
    @(negedge clk); ext_in = 32'hA5A5_5A5A;
    lg_rd(4'h0, r); check("R4 one edge", r, 32'h0);
    lg_rd(4'h0, r); check("R4 two edges", r, 32'hA5A5_5A5A);

    lg_wr(4'h8, 32'hFFFF_FFFF);
    #1;
    check("R5 legacy oe", pad_oe, 32'hFFFF_FFFF);
    check("R5 legacy out", pad_out, 32'h8000_5679);
    repeat (3) @(negedge clk);
    lg_rd(4'h0, r); check("R4 output pins", r, 32'h8000_5679);

    // Independence and bank switch
    fs_rd(5'h0C, r); check("R6 fast latch untouched", r, 32'h0);
    fs_rd(5'h00, r); check("R6 fast dir untouched", r, 32'h0);
    @(negedge clk); bank_sel = 1'b1;
    #1;
    check("R5 fast oe", pad_oe, 32'h0);
    check("R5 fast out", pad_out, 32'h0);

    // Byte enables
    fs_wr(5'h00, 4'b0011, 32'hFFFF_FFFF);
    fs_rd(5'h00, r); check("R7 dir lanes", r, 32'h0000_FFFF);
    fs_wr(5'h0C, 4'b0100, 32'hFFFF_FFFF);
    fs_rd(5'h0C, r); check("R7 set lane", r, 32'h00FF_0000);
    fs_wr(5'h0C, 4'b0000, 32'hFFFF_FFFF);
    fs_rd(5'h0C, r); check("R7 no lane", r, 32'h00FF_0000);
    fs_wr(5'h08, 4'b1111, 32'h1234_5678);
    fs_rd(5'h0C, r); check("R10 fast pin wr", r, 32'h1234_5678);
    #1;
    check("R5 fast out drives", pad_out, 32'h1234_5678);
    check("R5 fast oe drives", pad_oe, 32'h0000_FFFF);
    lg_rd(4'h4, r); check("R6 legacy latch kept", r, 32'h8000_5679);
    lg_rd(4'h8, r); check("R6 legacy dir kept", r, 32'hFFFF_FFFF);

    // Mask shielding
    fs_wr(5'h04, 4'b1111, 32'h0000_FF00);
    fs_wr(5'h0C, 4'b1111, 32'hFFFF_FFFF);
    fs_rd(5'h0C, r); check("R8 masked set", r, 32'hFFFF_56FF);
    fs_wr(5'h10, 4'b1111, 32'hFFFF_FFFF);
    fs_rd(5'h0C, r); check("R8 masked clr", r, 32'h0000_5600);
    fs_wr(5'h08, 4'b1111, 32'h0000_0000);
    fs_rd(5'h0C, r); check("R8 masked pin wr", r, 32'h0000_5600);
    repeat (3) @(negedge clk);
    fs_rd(5'h08, r); check("R8 masked pin read", r, 32'hA5A5_0000);

    // Unmapped offsets
    fs_wr(5'h14, 4'b1111, 32'hFFFF_FFFF);
    fs_rd(5'h14, r); check("R9 fast unmapped read", r, 32'h0);
    fs_rd(5'h10, r); check("R9 fast clr read", r, 32'h0);
    fs_rd(5'h0C, r); check("R9 fast latch kept", r, 32'h0000_5600);
    fs_rd(5'h04, r); check("R9 fast mask kept", r, 32'h0000_FF00);
    fs_rd(5'h00, r); check("R9 fast dir kept", r, 32'h0000_FFFF);
    lg_wr(4'h2, 32'hFFFF_FFFF);
    lg_rd(4'h2, r); check("R9 legacy unmapped read", r, 32'h0);
    lg_rd(4'h4, r); check("R9 legacy latch kept", r, 32'h8000_5679);
    lg_rd(4'h8, r); check("R9 legacy dir kept", r, 32'hFFFF_FFFF);

    // Reset in mid-run
    @(negedge clk); rst_ni = 1'b0;
    #1;
    check("R1 oe on reset", pad_oe, 32'h0);
    check("R1 out on reset", pad_out, 32'h0);
    lg_rd(4'h4, r); check("R1 legacy latch on reset", r, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule